// File: doc/BRIEF.md
# Serial EEPROM Bulk Fill Engine

This block is the internal engine of a three-wire serial EEPROM that carries out the two whole-array instructions: fill-all and clear-all. A serial front end, which is not part of this block, shifts in an instruction and presents it as one decoded word for one clock. That word holds a two-bit opcode, an address field and a 16-bit data field. The engine acts only on the system opcode `00`. For that opcode, the two leading bits of the address field act as a sub-operation, and the rest of the field is a dummy.

After the engine accepts a fill or clear, it writes the same value into every location of an internal register-file array, one location per clock in ascending order. It holds `busy` for a programmed number of cycles, which stands in for the non-volatile write time. Completion can only be seen as the fall of `busy`. A strap selects between byte (x8) and word (x16) organisation. Bulk operations are guarded by an internal write-enable latch, which the system opcode also sets and clears. A combinational read port shows the array contents in the current organisation.

Top module: `bulk_fill_engine`

## Requirements
- R1: After reset every array byte reads `FF`, `busy` is low and the write-enable latch is clear.
- R2: With the latch set and `wide_org`=0, opcode `00` with address bits [6:5]=`01` writes `req_data[7:0]` into all 128 byte locations. The other address bits and `req_data[15:8]` are don't-care.
- R3: With the latch set and `wide_org`=1, opcode `00` with address bits [5:4]=`01` writes `req_data` into all 64 word locations. A word's low byte sits at the even byte.
- R4: Opcode `00` with sub-operation `10` (x8: bits [6:5]; x16: bits [5:4]) sets every location to all ones.
- R5: `busy` rises on the clock edge that accepts a bulk request and stays high for exactly `CYCLES` cycles (default 200).
- R6: Any request seen while `busy` is high is ignored. It neither restarts the cycle nor changes the array.
- R7: While the latch is clear, a bulk request is dropped: `busy` stays low and the array is unchanged.
- R8: Opcode `00` with sub-operation `11` sets the latch, and sub-operation `00` clears it.
- R9: Opcodes `01`, `10` and `11` have no effect on this engine, even when the latch is set.
- R10: Location p is written on the (p+1)-th clock edge after the accepting edge, in ascending order, one location per clock. `rd_data` shows the new value combinationally after that edge. In x8 the upper byte of `rd_data` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_org | input | 1 | Organisation strap: 1 = 16-bit words, 0 = bytes |
| req_valid | input | 1 | Decoded instruction present for one clock |
| req_opcode | input | 2 | Instruction opcode |
| req_addr | input | ADDR_W8 | Address field; top bits of the current organisation carry the sub-operation |
| req_data | input | 16 | Data operand |
| rd_addr | input | ADDR_W8 | Read location in the current organisation |
| rd_data | output | 16 | Array contents at `rd_addr` |
| busy | output | 1 | High while a bulk cycle is running |

## Verification
A request driven before clock edge k is accepted at edge k. `busy` is therefore high from the sample after edge k, and low again from the sample after edge k+CYCLES. The array location p changes after edge k+1+p, and the read port follows with no further register. The bench's reference model steps on every rising edge with those same delays. Comparisons of `busy` and `rd_data` are taken a quarter period after the edge, and inputs change on falling edges. The directed checks count busy length in falling edges and probe locations 0 and 1 on the first two edges after acceptance.

// File: rtl/bulk_fill_pkg.sv
// Shared types for the bulk fill engine.
// Assumes: the system opcode carries a two-bit sub-operation in the
// leading bits of the address field of the active organisation.
package bulk_fill_pkg;

    localparam logic [1:0] OPC_SYS = 2'b00;

    typedef enum logic [1:0] {
        SUB_LOCK   = 2'b00,
        SUB_FILL   = 2'b01,
        SUB_CLEAR  = 2'b10,
        SUB_UNLOCK = 2'b11
    } subop_e;

    typedef struct packed {
        logic        start;
        logic        wide;
        logic [15:0] value;
    } fill_cmd_t;

endpackage

// File: rtl/bulk_cmd_decode.sv
// Decodes the system opcode and keeps the write-enable latch.
// Assumes: requests are single-cycle pulses and are ignored while busy.
module bulk_cmd_decode
    import bulk_fill_pkg::*;
#(
    parameter int AW8 = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             wide_org,
    input  logic             req_valid,
    input  logic [1:0]       req_opcode,
    input  logic [AW8-1:0]   req_addr,
    input  logic [15:0]      req_data,
    output fill_cmd_t        cmd,
    output logic             wel
);

    subop_e sub;
    logic   sys_hit;

    // Pick the sub-operation from the leading bits of the active address length.
    always_comb begin
        if (wide_org) begin
            sub = subop_e'(req_addr[AW8-2 -: 2]);
        end else begin
            sub = subop_e'(req_addr[AW8-1 -: 2]);
        end
        sys_hit = req_valid && !busy && (req_opcode == OPC_SYS);
    end

    // Write-enable latch: set by unlock, cleared by lock or reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel <= 1'b0;
        end else if (sys_hit && sub == SUB_UNLOCK) begin
            wel <= 1'b1;
        end else if (sys_hit && sub == SUB_LOCK) begin
            wel <= 1'b0;
        end
    end

    // Form the bulk command and the value it spreads.
    always_comb begin
        cmd.start = sys_hit && wel && (sub == SUB_FILL || sub == SUB_CLEAR);
        cmd.wide  = wide_org;
        if (sub == SUB_CLEAR) begin
            cmd.value = 16'hFFFF;
        end else if (wide_org) begin
            cmd.value = req_data;
        end else begin
            cmd.value = {8'h00, req_data[7:0]};
        end
    end

endmodule

// File: rtl/bulk_busy_timer.sv
// Holds busy for exactly CYCLES clocks after a start pulse.
// Assumes: start is only raised while busy is low.
module bulk_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count the programmed duration and drop busy on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
                busy <= 1'b0;
            end
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/bulk_fill_seq.sv
// Walks the location pointer from zero to the last location of the
// organisation latched at start, issuing one array write per clock.
// Assumes: CYCLES of the timer is at least the location count.
module bulk_fill_seq #(
    parameter int AW8 = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           wide_in,
    input  logic [15:0]    value_in,
    output logic           we,
    output logic           wide,
    output logic [AW8-1:0] waddr,
    output logic [15:0]    wdata
);

    localparam int DEPTH8 = 1 << AW8;
    localparam logic [AW8-1:0] LAST8  = AW8'(DEPTH8 - 1);
    localparam logic [AW8-1:0] LAST16 = AW8'(DEPTH8 / 2 - 1);

    logic           filling_q;
    logic [AW8-1:0] ptr_q;
    logic [AW8-1:0] last;

    // Last location of the latched organisation.
    always_comb last = wide ? LAST16 : LAST8;

    // Latch operand and organisation, then advance one location per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filling_q <= 1'b0;
            ptr_q     <= '0;
            wide      <= 1'b0;
            wdata     <= 16'hFFFF;
        end else if (filling_q) begin
            ptr_q <= ptr_q + 1'b1;
            if (ptr_q == last) begin
                filling_q <= 1'b0;
            end
        end else if (start) begin
            filling_q <= 1'b1;
            ptr_q     <= '0;
            wide      <= wide_in;
            wdata     <= value_in;
        end
    end

    // Drive the array write port from the sequencer state.
    always_comb begin
        we    = filling_q;
        waddr = ptr_q;
    end

endmodule

// File: rtl/bulk_byte_array.sv
// Byte-wide register file standing in for the non-volatile array.
// Word writes touch two bytes (low byte at the even address).
// Assumes: AW8 >= 3; the read port follows the current strap.
module bulk_byte_array #(
    parameter int AW8 = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic           wide,
    input  logic [AW8-1:0] waddr,
    input  logic [15:0]    wdata,
    input  logic           rd_wide,
    input  logic [AW8-1:0] rd_addr,
    output logic [15:0]    rd_data
);

    localparam int DEPTH8 = 1 << AW8;

    logic [DEPTH8*8-1:0] flat;
    logic [AW8-1:0]      rd_lo;

    for (genvar i = 0; i < DEPTH8; i++) begin : g_byte
        localparam logic [AW8-1:0] IDX = AW8'(i);
        logic       hit;
        logic [7:0] d;
        logic [7:0] byte_q;

        // Decide whether this byte is addressed and which half it takes.
        always_comb begin
            if (wide) begin
                hit = we && (waddr[AW8-2:0] == IDX[AW8-1:1]);
                d   = IDX[0] ? wdata[15:8] : wdata[7:0];
            end else begin
                hit = we && (waddr == IDX);
                d   = wdata[7:0];
            end
        end

        // Storage cell, all ones after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= 8'hFF;
            end else if (hit) begin
                byte_q <= d;
            end
        end

        assign flat[i*8 +: 8] = byte_q;
    end

    // Read mux in the organisation currently strapped.
    always_comb begin
        if (rd_wide) begin
            rd_lo   = {rd_addr[AW8-2:0], 1'b0};
            rd_data = flat[{rd_lo, 3'b000} +: 16];
        end else begin
            rd_lo   = rd_addr;
            rd_data = {8'h00, flat[{rd_lo, 3'b000} +: 8]};
        end
    end

endmodule

// File: rtl/bulk_fill_engine.sv
// Whole-array fill/clear engine of a serial EEPROM.
// Takes decoded instructions, spreads one value over the whole array and
// reports busy for the programmed write time.
// Assumes: CYCLES >= 2**ADDR_W8 so the fill ends inside the busy window.
module bulk_fill_engine
    import bulk_fill_pkg::*;
#(
    parameter int ADDR_W8 = 7,
    parameter int CYCLES  = 200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide_org,
    input  logic               req_valid,
    input  logic [1:0]         req_opcode,
    input  logic [ADDR_W8-1:0] req_addr,
    input  logic [15:0]        req_data,
    input  logic [ADDR_W8-1:0] rd_addr,
    output logic [15:0]        rd_data,
    output logic               busy
);

    fill_cmd_t           cmd;
    logic                wel;
    logic                arr_we;
    logic                arr_wide;
    logic [ADDR_W8-1:0]  arr_addr;
    logic [15:0]         arr_data;

    bulk_cmd_decode #(.AW8(ADDR_W8)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy       (busy),
        .wide_org   (wide_org),
        .req_valid  (req_valid),
        .req_opcode (req_opcode),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .cmd        (cmd),
        .wel        (wel)
    );

    bulk_busy_timer #(.CYCLES(CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cmd.start),
        .busy  (busy)
    );

    bulk_fill_seq #(.AW8(ADDR_W8)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd.start),
        .wide_in  (cmd.wide),
        .value_in (cmd.value),
        .we       (arr_we),
        .wide     (arr_wide),
        .waddr    (arr_addr),
        .wdata    (arr_data)
    );

    bulk_byte_array #(.AW8(ADDR_W8)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .wide    (arr_wide),
        .waddr   (arr_addr),
        .wdata   (arr_data),
        .rd_wide (wide_org),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/bulk_fill_engine_chk.sv
// Temporal checks on the bulk fill engine, bound to its top.
module bulk_fill_engine_chk #(
    parameter int CYCLES = 200,
    parameter int AW8    = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           wel,
    input logic           arr_we,
    input logic [AW8-1:0] arr_addr
);

    localparam int RW = $clog2(CYCLES + 2);

    logic [RW-1:0] run_q;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R5
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RW'(CYCLES));

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_q < RW'(CYCLES));

    // R7
    locked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wel && !busy) |=> !busy);

    // R10
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    // R10
    ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> arr_addr == $past(arr_addr) + 1'b1);

endmodule

bind bulk_fill_engine bulk_fill_engine_chk #(
    .CYCLES (CYCLES),
    .AW8    (ADDR_W8)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wel      (wel),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/test_bulk_fill_engine.sv
module test_bulk_fill_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW8 = 7;
    localparam int CYC = 200;
    localparam int NB  = 1 << AW8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           wide_org;
    logic           req_valid;
    logic [1:0]     req_opcode;
    logic [AW8-1:0] req_addr;
    logic [15:0]    req_data;
    logic [AW8-1:0] rd_addr;
    logic [15:0]    rd_data;
    logic           busy;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit sweep = 0;
    bit done = 0;

    bulk_fill_engine #(.ADDR_W8(AW8), .CYCLES(CYC)) i_bulk_fill_engine (
        .clk(clk), .rst_n(rst_n), .wide_org(wide_org), .req_valid(req_valid),
        .req_opcode(req_opcode), .req_addr(req_addr), .req_data(req_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [7:0]  m_mem [NB];
    bit          m_busy = 0;
    bit          m_wel = 0;
    bit          m_wide = 0;
    int          m_t = 0;
    int          m_locs = NB;
    logic [15:0] m_val = 16'hFFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
            m_busy = 0; m_wel = 0; m_t = 0;
        end else if (m_busy) begin
            m_t++;
            if (m_t <= m_locs) begin
                if (m_wide) begin
                    m_mem[2*(m_t-1)]   = m_val[7:0];
                    m_mem[2*(m_t-1)+1] = m_val[15:8];
                end else begin
                    m_mem[m_t-1] = m_val[7:0];
                end
            end
            if (m_t == CYC) m_busy = 0;
        end else if (req_valid && req_opcode == 2'b00) begin
            logic [1:0] sub;
            sub = wide_org ? req_addr[AW8-2 -: 2] : req_addr[AW8-1 -: 2];
            if (sub == 2'b11) m_wel = 1;
            else if (sub == 2'b00) m_wel = 0;
            else if (m_wel) begin
                m_busy = 1; m_t = 0; m_wide = wide_org;
                m_locs = wide_org ? NB/2 : NB;
                if (sub == 2'b10) m_val = 16'hFFFF;
                else m_val = wide_org ? req_data : {8'h00, req_data[7:0]};
            end
        end
    end

    function automatic logic [15:0] model_read(logic [AW8-1:0] a);
        if (wide_org) begin
            int lo;
            lo = {a[AW8-2:0], 1'b0};
            return {m_mem[lo+1], m_mem[lo]};
        end
        return {8'h00, m_mem[a]};
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (started && rst_n) begin
            chk("R5 busy vs model", {15'b0, busy}, {15'b0, m_busy});
            chk("R10 rd_data vs model", rd_data, model_read(rd_addr));
            if (sweep) rd_addr = rd_addr + 1'b1;
        end
    end

    task automatic issue(logic [1:0] opc, logic [AW8-1:0] addr, logic [15:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_opcode = opc; req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Sub-operation placed in the leading bits of the active address length
    function automatic logic [AW8-1:0] sub_addr(logic [1:0] sub, logic [AW8-1:0] junk);
        logic [AW8-1:0] a;
        a = junk;
        if (wide_org) begin a[AW8-1] = 1'b0; a[AW8-2 -: 2] = sub; end
        else a[AW8-1 -: 2] = sub;
        return a;
    endfunction

    task automatic check_fill(string tag, logic [15:0] exp);
        int n;
        sweep = 0;
        n = wide_org ? NB/2 : NB;
        for (int a = 0; a < n; a++) begin
            @(negedge clk);
            rd_addr = AW8'(a);
            #1;
            chk(tag, rd_data, exp);
        end
        sweep = 1;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        rst_n = 0; wide_org = 0; req_valid = 0; req_opcode = 0;
        req_addr = 0; req_data = 0; rd_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        started = 1;

        // R1: reset contents and idle
        chk("R1 busy after reset", {15'b0, busy}, 16'h0);
        check_fill("R1 array all ones", 16'h00FF);

        // R7: latch clear after reset, fill dropped
        issue(2'b00, sub_addr(2'b01, 7'h15), 16'h003C);
        repeat (4) @(negedge clk);
        chk("R7 no busy while locked", {15'b0, busy}, 16'h0);
        check_fill("R7 array unchanged", 16'h00FF);

        // R8 unlock, then R2 byte fill with junk address bits and upper data
        issue(2'b00, sub_addr(2'b11, 7'h0A), 16'h0);
        issue(2'b00, sub_addr(2'b01, 7'h1B), 16'h77A5);
        chk("R5 busy right after accept", {15'b0, busy}, 16'h1);
        wait_idle(n);
        chk("R5 busy length", 16'(n), 16'(CYC));
        check_fill("R2 byte fill", 16'h00A5);

        // R3 word fill, R6 second request during busy ignored
        wide_org = 1;
        issue(2'b00, sub_addr(2'b01, 7'h05), 16'h1234);
        repeat (48) @(negedge clk);
        issue(2'b00, sub_addr(2'b10, 7'h00), 16'h0);
        wait_idle(n);
        chk("R6 no restart, busy length", 16'(n + 50), 16'(CYC));
        check_fill("R3 word fill (R6 clear ignored)", 16'h1234);
        wide_org = 0;
        @(negedge clk);
        rd_addr = 7'd1; #1;
        chk("R3 odd byte holds high half", rd_data, 16'h0012);

        // R4 clear-all in byte mode
        issue(2'b00, sub_addr(2'b10, 7'h1F), 16'h0);
        wait_idle(n);
        check_fill("R4 clear all", 16'h00FF);

        // R9 other opcodes have no effect
        issue(2'b01, 7'h20, 16'h0011);
        issue(2'b10, 7'h20, 16'h0022);
        issue(2'b11, 7'h20, 16'h0033);
        @(negedge clk);
        chk("R9 no busy for other opcodes", {15'b0, busy}, 16'h0);
        check_fill("R9 array unchanged", 16'h00FF);

        // R10 write order: location 0 after first edge, location 1 after second
        sweep = 0;
        issue(2'b00, sub_addr(2'b01, 7'h00), 16'h005A);
        rd_addr = 7'd0; #1;
        chk("R10 loc0 before first write edge", rd_data, 16'h00FF);
        @(negedge clk);
        rd_addr = 7'd0; #1;
        chk("R10 loc0 after first write edge", rd_data, 16'h005A);
        rd_addr = 7'd1; #1;
        chk("R10 loc1 not yet written", rd_data, 16'h00FF);
        @(negedge clk);
        chk("R10 loc1 after second write edge", rd_data, 16'h005A);
        sweep = 1;
        wait_idle(n);

        // R8 lock, then fill is dropped
        issue(2'b00, sub_addr(2'b00, 7'h13), 16'h0);
        issue(2'b00, sub_addr(2'b01, 7'h00), 16'h0099);
        repeat (3) @(negedge clk);
        chk("R8 locked, no busy", {15'b0, busy}, 16'h0);
        check_fill("R8 array keeps last fill", 16'h005A);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule